// File: doc/BRIEF.md
# Floppy Controller Register File with Seek Stepper and Microsecond Timer

This block is the host-facing register file of a floppy disk controller. A byte-wide host bus reaches sixteen registers. The register index is taken from address bits 7:4, so consecutive registers are sixteen bytes apart. The low address nibble is ignored.

The control byte has no plain write. One address clears the bits written as 1, and a second address sets them. A read of that second address returns a composed status byte instead. Interrupt causes latch into a cause register, which is read-to-clear. The causes are a finished timer countdown, a finished seek, three pulses from the data path, and any error flag. An enable register masks the causes, and the result is gated by a global enable bit in the control byte. The error register is also read-to-clear.

A seek engine turns a step count into evenly spaced step pulses toward the drive. It counts the value down to zero and then flags completion. A separate down-counter is loaded in microseconds and flags its own completion when it reaches zero.

Top module: `fdc_regs_seek`

## Requirements
- R1: Address bits 7:4 select the register and bits 3:0 are ignored. The following registers read back the last byte written to them:
  - index 0 (data), 3 (mode), 4 (select), 10 (current track), 11 (current sector), 12 (gap length), 13 (target sector) and 14 (sector count);
  - index 15 (interrupt enable), whose bits 5:0 are stored and whose bits 7:6 read 0.
  The low four bits of the select register drive `drive_sel_o`.
- R2: A write to index 6 clears every control bit written as 1 and leaves the others alone. A read of index 6 returns the control byte, which also appears on `ctrl_o`. Control bit 7 starts a seek and bit 0 is the global interrupt enable.
- R3: A write to index 7 sets every control bit written as 1 and leaves the others alone.
- R4: A read of index 7 returns status, with these bits:
  - bit 7 is `fifo_one`, bit 6 is `fifo_two`, bit 5 is 1 when the error register is nonzero, and bit 4 is 0;
  - bit 3 is the raw `sense_n` pin, bit 2 is `rddata_in`, bit 1 is the interrupt-pending condition and bit 0 is `mark_in`.
- R5: The cause register at index 8 has these bits: 0 timer done, 1 seek done, 2 sector seen (`evt_sector`), 3 transfer done (`evt_xfer`), 4 data changed (`evt_datachg`) and 5 error. Its bits 7:6 read 0. A read of index 8 returns its value, then clears it and the error register. A cause arriving in the same cycle as the clearing read is kept.
- R6: Bits of `err_in` at positions 7 (data CRC), 6 (address CRC), 2 (overrun) and 0 (underrun) latch into the error register at index 2. Other positions are dropped. Any latched error also sets cause bit 5. A read of index 2 returns the flags and clears only the error register.
- R7: While control bit 7 is 1 and the step count at index 9 is nonzero, `step_o` pulses. Each pulse is STEP_HIGH clocks high, and a new pulse starts every STEP_PERIOD clocks. The count drops by one per step and can be read back. Starting with count N, cause bit 1 is set at the Nth STEP_PERIOD boundary after the start, and the count then reads 0.
- R8: Clearing control bit 7 during a seek stops the pulses at once, and the remaining step count is held.
- R9: A write to index 1 loads the timer. A nonzero value drops by one every CLK_PER_US clocks. Loading V sets cause bit 0 exactly V*CLK_PER_US clocks after the write, and the timer then reads 0.
- R10: `irq_o` is 1 when control bit 0 is 1 and the cause register ANDed with the enable register is nonzero. Causes outside the enable mask neither raise `irq_o` nor set status bit 1.
- R11: Writing the setup register (index 5) with bit 7 set does two things:
  - it clears the control byte, the cause register, the error register and the step count;
  - setup bit 7 is not stored and reads 0, while bits 6:0 are stored.
- R12: After reset every register reads 0, `irq_o` is 0 and `step_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Host byte address; bits 7:4 pick the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; triggers read-to-clear side effects |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| err_in | input | 8 | Error flag pulses from the data path |
| evt_sector | input | 1 | Sector-seen pulse |
| evt_xfer | input | 1 | Transfer-done pulse |
| evt_datachg | input | 1 | Data-changed pulse |
| fifo_one | input | 1 | FIFO holds one byte |
| fifo_two | input | 1 | FIFO holds two bytes |
| mark_in | input | 1 | Mark byte seen |
| rddata_in | input | 1 | Raw read data level |
| sense_n | input | 1 | Drive sense line, active low |
| ctrl_o | output | 8 | Current control byte |
| drive_sel_o | output | 4 | Drive select lines from the select register |
| step_o | output | 1 | Step pulse to the drive |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with CLK_PER_US = 4, STEP_PERIOD = 16 and STEP_HIGH = 8. With these values a five-microsecond countdown ends after 20 clocks, and a three-step seek ends after 48 clocks. This lets every pulse edge and the exact completion cycle be counted clock by clock. A halted seek can also be stopped part-way through its second step and watched afterwards for stray pulses.

// File: rtl/fdc_pkg.sv
// Shared register indices and bit positions for the floppy register file.
// Assumes one byte register per 16-byte address slot.
package fdc_pkg;
    localparam int REG_W = 8;
    localparam int INT_W = 6;

    typedef enum logic [3:0] {
        IDX_DATA     = 4'd0,
        IDX_TIMER    = 4'd1,
        IDX_ERROR    = 4'd2,
        IDX_MODE     = 4'd3,
        IDX_SELECT   = 4'd4,
        IDX_SETUP    = 4'd5,
        IDX_CTRL_CLR = 4'd6,
        IDX_CTRL_SET = 4'd7,
        IDX_INTR     = 4'd8,
        IDX_NSEEK    = 4'd9,
        IDX_CTRACK   = 4'd10,
        IDX_CSECT    = 4'd11,
        IDX_GAP      = 4'd12,
        IDX_SECTOR   = 4'd13,
        IDX_NSECT    = 4'd14,
        IDX_IEN      = 4'd15
    } reg_idx_e;

    // Registers that only store what the host writes.
    localparam logic [15:0] PLAIN_MASK = 16'b0111_1100_0001_1001;

    localparam int CTL_SEEK   = 7;
    localparam int CTL_IRQ_EN = 0;
    localparam int SETUP_SRST = 7;

    localparam int INT_TIMER  = 0;
    localparam int INT_SEEK   = 1;
    localparam int INT_SECTOR = 2;
    localparam int INT_XFER   = 3;
    localparam int INT_DCHG   = 4;
    localparam int INT_ERR    = 5;

    localparam logic [REG_W-1:0] ERR_MASK = 8'hC5;
endpackage

// File: rtl/fdc_us_timer.sv
// Microsecond down-counter. A prescaler divides the clock by CLK_PER_US
// while the count is nonzero. A one-cycle done pulse marks the step to zero.
// Assumes CLK_PER_US >= 2.
module fdc_us_timer #(
    parameter int CLK_PER_US = 100,
    parameter int W          = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] value_o,
    output logic         done_o
);
    localparam int PW = $clog2(CLK_PER_US + 1);
    localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_US - 1);

    logic [PW-1:0] pre_q;
    logic [W-1:0]  val_q;
    logic          tick;

    assign tick    = (pre_q == PRE_LAST);
    assign value_o = val_q;
    assign done_o  = !load_i && (val_q == W'(1)) && tick;

    // Load, prescale and count the microsecond value down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            val_q <= '0;
        end else if (load_i) begin
            pre_q <= '0;
            val_q <= load_val_i;
        end else if (val_q != '0) begin
            if (tick) begin
                pre_q <= '0;
                val_q <= val_q - W'(1);
            end else begin
                pre_q <= pre_q + PW'(1);
            end
        end else begin
            pre_q <= '0;
        end
    end

    assert_timer_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (val_q == '0));
endmodule

// File: rtl/fdc_seek_engine.sv
// Seek stepper. While start_i is high and the count is nonzero, it emits one
// pulse of STEP_HIGH clocks every STEP_PERIOD clocks and decrements the count
// at the end of each period. It pulses done_o on the last step.
// Assumes STEP_HIGH < STEP_PERIOD.
module fdc_seek_engine #(
    parameter int STEP_HIGH   = 8,
    parameter int STEP_PERIOD = 64,
    parameter int W           = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         srst_i,
    input  logic         start_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] count_o,
    output logic         step_o,
    output logic         done_o
);
    localparam int PW = $clog2(STEP_PERIOD + 1);
    localparam logic [PW-1:0] PH_LAST = PW'(STEP_PERIOD - 1);
    localparam logic [PW-1:0] PH_HIGH = PW'(STEP_HIGH);

    logic [W-1:0]  cnt_q;
    logic [PW-1:0] ph_q;
    logic          busy;

    assign busy    = start_i && (cnt_q != '0);
    assign step_o  = busy && (ph_q < PH_HIGH);
    assign done_o  = busy && !load_i && !srst_i && (ph_q == PH_LAST) && (cnt_q == W'(1));
    assign count_o = cnt_q;

    // Advance the step phase and count steps down while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_i) begin
            cnt_q <= '0;
            ph_q  <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
            ph_q  <= '0;
        end else if (busy) begin
            if (ph_q == PH_LAST) begin
                ph_q  <= '0;
                cnt_q <= cnt_q - W'(1);
            end else begin
                ph_q <= ph_q + PW'(1);
            end
        end else begin
            ph_q <= '0;
        end
    end

    assert_seek_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (cnt_q == '0));
    assert_halt_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !load_i && !srst_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/fdc_irq_ctrl.sv
// Cause and error latches. New events OR into the latches. A read clears them.
// A new event in the same cycle as a clearing read survives. Soft reset wins.
module fdc_irq_ctrl
    import fdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst_i,
    input  logic [INT_W-2:0] cause_i,
    input  logic [REG_W-1:0] err_i,
    input  logic             rd_intr_i,
    input  logic             rd_err_i,
    output logic [INT_W-1:0] intr_o,
    output logic [REG_W-1:0] err_o
);
    logic [INT_W-1:0] intr_q;
    logic [REG_W-1:0] err_q;
    logic [REG_W-1:0] err_new;
    logic [INT_W-1:0] intr_set;

    assign err_new  = err_i & ERR_MASK;
    assign intr_set = {(err_new != '0), cause_i};
    assign intr_o   = intr_q;
    assign err_o    = err_q;

    // Latch causes and errors with read-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_i) begin
            intr_q <= '0;
            err_q  <= '0;
        end else begin
            intr_q <= (rd_intr_i ? '0 : intr_q) | intr_set;
            err_q  <= ((rd_intr_i || rd_err_i) ? '0 : err_q) | err_new;
        end
    end

    assert_rdclr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_intr_i && cause_i == '0 && err_i == '0) |=> (intr_q == '0 && err_q == '0));
    assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_new != '0 && !srst_i) |=> intr_q[INT_ERR]);
endmodule

// File: rtl/fdc_regs_seek.sv
// Floppy controller register file top. It decodes sixteen byte registers,
// applies set and clear writes to the control byte, composes status, and
// combines the interrupt. It instantiates the timer, the seek engine and
// the interrupt latches. Assumes one bus access per cycle and a
// combinational read path.
module fdc_regs_seek
    import fdc_pkg::*;
#(
    parameter int CLK_PER_US  = 100,
    parameter int STEP_HIGH   = 8,
    parameter int STEP_PERIOD = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic [7:0] err_in,
    input  logic       evt_sector,
    input  logic       evt_xfer,
    input  logic       evt_datachg,
    input  logic       fifo_one,
    input  logic       fifo_two,
    input  logic       mark_in,
    input  logic       rddata_in,
    input  logic       sense_n,
    output logic [7:0] ctrl_o,
    output logic [3:0] drive_sel_o,
    output logic       step_o,
    output logic       irq_o
);
    reg_idx_e         idx;
    logic             unused_addr_bits;
    logic [REG_W-1:0] plain_q [16];
    logic [REG_W-1:0] ctrl_q;
    logic [6:0]       setup_q;
    logic [INT_W-1:0] ien_q;
    logic             srst;
    logic [REG_W-1:0] timer_val, nseek_val, err_val, status;
    logic [INT_W-1:0] intr_val;
    logic             timer_done, seek_done, pending;

    assign idx              = reg_idx_e'(bus_addr[7:4]);
    assign unused_addr_bits = ^bus_addr[3:0];
    assign srst             = bus_wr && (idx == IDX_SETUP) && bus_wdata[SETUP_SRST];

    // Plain storage registers, one per index marked in PLAIN_MASK.
    for (genvar i = 0; i < 16; i++) begin : g_plain
        if (PLAIN_MASK[i]) begin : g_store
            // Store host writes to this index.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    plain_q[i] <= '0;
                else if (bus_wr && idx == reg_idx_e'(i))
                    plain_q[i] <= bus_wdata;
            end
        end else begin : g_none
            assign plain_q[i] = '0;
        end
    end

    // Control byte: clear-bits and set-bits writes, cleared by soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || srst)
            ctrl_q <= '0;
        else if (bus_wr && idx == IDX_CTRL_CLR)
            ctrl_q <= ctrl_q & ~bus_wdata;
        else if (bus_wr && idx == IDX_CTRL_SET)
            ctrl_q <= ctrl_q | bus_wdata;
    end

    // Setup and interrupt-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_q <= '0;
            ien_q   <= '0;
        end else if (bus_wr) begin
            if (idx == IDX_SETUP) setup_q <= bus_wdata[6:0];
            if (idx == IDX_IEN)   ien_q   <= bus_wdata[INT_W-1:0];
        end
    end

    fdc_us_timer #(.CLK_PER_US(CLK_PER_US), .W(REG_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (bus_wr && idx == IDX_TIMER),
        .load_val_i (bus_wdata),
        .value_o    (timer_val),
        .done_o     (timer_done)
    );

    fdc_seek_engine #(.STEP_HIGH(STEP_HIGH), .STEP_PERIOD(STEP_PERIOD), .W(REG_W)) u_seek (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst_i     (srst),
        .start_i    (ctrl_q[CTL_SEEK]),
        .load_i     (bus_wr && idx == IDX_NSEEK),
        .load_val_i (bus_wdata),
        .count_o    (nseek_val),
        .step_o     (step_o),
        .done_o     (seek_done)
    );

    fdc_irq_ctrl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst_i    (srst),
        .cause_i   ({evt_datachg, evt_xfer, evt_sector, seek_done, timer_done}),
        .err_i     (err_in),
        .rd_intr_i (bus_rd && idx == IDX_INTR),
        .rd_err_i  (bus_rd && idx == IDX_ERROR),
        .intr_o    (intr_val),
        .err_o     (err_val)
    );

    // Interrupt combine and status composition.
    always_comb begin
        pending = ctrl_q[CTL_IRQ_EN] && ((intr_val & ien_q) != '0);
        status  = {fifo_one, fifo_two, (err_val != '0), 1'b0,
                   sense_n, rddata_in, pending, mark_in};
    end

    // Read data multiplexer.
    always_comb begin
        case (idx)
            IDX_TIMER:    bus_rdata = timer_val;
            IDX_ERROR:    bus_rdata = err_val;
            IDX_SETUP:    bus_rdata = {1'b0, setup_q};
            IDX_CTRL_CLR: bus_rdata = ctrl_q;
            IDX_CTRL_SET: bus_rdata = status;
            IDX_INTR:     bus_rdata = {2'b00, intr_val};
            IDX_NSEEK:    bus_rdata = nseek_val;
            IDX_IEN:      bus_rdata = {2'b00, ien_q};
            default:      bus_rdata = plain_q[idx];
        endcase
    end

    assign irq_o       = pending;
    assign ctrl_o      = ctrl_q;
    assign drive_sel_o = plain_q[IDX_SELECT][3:0];

    assert_ctrl_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == IDX_CTRL_CLR) |=> ((ctrl_q & $past(bus_wdata)) == '0));
    assert_ctrl_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == IDX_CTRL_SET) |=> ((ctrl_q & $past(bus_wdata)) == $past(bus_wdata)));
    assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (ctrl_q == '0 && nseek_val == '0 && intr_val == '0));
    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[CTL_IRQ_EN] |-> !irq_o);
endmodule

// File: tb/fdc_regs_seek_tb_top.sv
module fdc_regs_seek_tb_top;
    localparam int K = 4;
    localparam int H = 8;
    localparam int P = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0, err_in = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic       evt_sector = 1'b0, evt_xfer = 1'b0, evt_datachg = 1'b0;
    logic       fifo_one = 1'b0, fifo_two = 1'b0, mark_in = 1'b0, rddata_in = 1'b0;
    logic       sense_n = 1'b1;
    logic [7:0] bus_rdata, ctrl_o;
    logic [3:0] drive_sel_o;
    logic       step_o, irq_o;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    fdc_regs_seek #(.CLK_PER_US(K), .STEP_HIGH(H), .STEP_PERIOD(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err_in(err_in),
        .evt_sector(evt_sector), .evt_xfer(evt_xfer), .evt_datachg(evt_datachg),
        .fifo_one(fifo_one), .fifo_two(fifo_two), .mark_in(mark_in), .rddata_in(rddata_in),
        .sense_n(sense_n), .ctrl_o(ctrl_o), .drive_sel_o(drive_sel_o),
        .step_o(step_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // All bus tasks start and end at a falling edge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] e, input logic s, input logic x, input logic c);
        err_in = e; evt_sector = s; evt_xfer = x; evt_datachg = c;
        @(posedge clk); @(negedge clk);
        err_in = '0; evt_sector = 1'b0; evt_xfer = 1'b0; evt_datachg = 1'b0;
    endtask

    task automatic test_reset();
        logic [7:0] v;
        for (int i = 0; i < 16; i++) begin
            if (i == 7) continue;
            rd(8'(i << 4), v);
            check("R12 reset reg", v, 0);
        end
        check("R12 irq", irq_o, 0);
        check("R12 step", step_o, 0);
    endtask

    task automatic test_plain();
        logic [7:0] v;
        int idxs[8] = '{0, 3, 4, 10, 11, 12, 13, 14};
        foreach (idxs[j]) wr(8'((idxs[j] << 4) | 4'hA), 8'(idxs[j] * 17 ^ 8'h5A));
        foreach (idxs[j]) begin
            rd(8'(idxs[j] << 4), v);
            check("R1 plain readback", v, 8'(idxs[j] * 17 ^ 8'h5A));
        end
        wr(8'h40, 8'h0B);
        check("R1 drive_sel", drive_sel_o, 4'hB);
        wr(8'hF0, 8'hFF);
        rd(8'hF3, v);
        check("R1 ien width", v, 8'h3F);
        wr(8'hF0, 8'h00);
    endtask

    task automatic test_ctrl();
        logic [7:0] v;
        wr(8'h70, 8'h5A);
        rd(8'h60, v);
        check("R3 set bits", v, 8'h5A);
        wr(8'h70, 8'h24);
        check("R3 set keeps others", ctrl_o, 8'h7E);
        wr(8'h60, 8'h42);
        rd(8'h60, v);
        check("R2 clear bits", v, 8'h3C);
        wr(8'h60, 8'hFF);
        check("R2 clear all", ctrl_o, 0);
    endtask

    task automatic test_status();
        logic [7:0] v;
        fifo_one = 1; fifo_two = 0; mark_in = 1; rddata_in = 1; sense_n = 0;
        rd(8'h70, v);
        check("R4 status pattern a", v, 8'h85);
        fifo_one = 0; fifo_two = 1; mark_in = 0; rddata_in = 0; sense_n = 1;
        rd(8'h70, v);
        check("R4 status pattern b", v, 8'h48);
        fifo_two = 0;
    endtask

    task automatic test_errors();
        logic [7:0] v;
        pulse(8'hFF, 0, 0, 0);
        rd(8'h70, v);
        check("R4 status error bit", v & 8'h20, 8'h20);
        rd(8'h20, v);
        check("R6 error mask", v, 8'hC5);
        rd(8'h20, v);
        check("R6 error read clears", v, 0);
        rd(8'h80, v);
        check("R6 error cause", v, 8'h20);
        pulse(8'h3A, 0, 0, 0);
        rd(8'h80, v);
        check("R6 unlisted bits dropped", v, 0);
        pulse(8'h80, 0, 0, 0);
        rd(8'h80, v);
        check("R5 intr read", v, 8'h20);
        rd(8'h20, v);
        check("R5 intr read clears error", v, 0);
    endtask

    task automatic test_events();
        logic [7:0] v;
        pulse(0, 1, 0, 0);
        pulse(0, 0, 1, 0);
        pulse(0, 0, 0, 1);
        rd(8'h80, v);
        check("R5 event bits", v, 8'h1C);
        rd(8'h80, v);
        check("R5 read clears", v, 0);
        // A cause pulsed in the same cycle as the clearing read survives.
        bus_addr = 8'h80; bus_rd = 1'b1; evt_xfer = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0; evt_xfer = 1'b0;
        rd(8'h80, v);
        check("R5 set beats clear", v, 8'h08);
    endtask

    task automatic test_irq_mask();
        logic [7:0] v;
        wr(8'hF0, 8'h04);
        wr(8'h70, 8'h01);
        pulse(0, 0, 1, 0);
        check("R10 masked cause irq", irq_o, 0);
        rd(8'h70, v);
        check("R10 masked cause pending", v & 8'h02, 0);
        pulse(0, 1, 0, 0);
        check("R10 enabled cause irq", irq_o, 1);
        rd(8'h70, v);
        check("R10 pending bit", v & 8'h02, 8'h02);
        wr(8'h60, 8'h01);
        check("R10 global enable off", irq_o, 0);
        rd(8'h80, v);
    endtask

    task automatic test_timer();
        logic [7:0] v;
        wr(8'hF0, 8'h01);
        wr(8'h70, 8'h01);
        wr(8'h10, 8'd5);
        repeat (5 * K - 1) @(negedge clk);
        check("R9 timer not yet", irq_o, 0);
        @(negedge clk);
        check("R9 timer done on time", irq_o, 1);
        rd(8'h10, v);
        check("R9 timer at zero", v, 0);
        rd(8'h80, v);
        check("R9 timer cause bit", v, 8'h01);
        wr(8'h60, 8'hFF);
    endtask

    task automatic test_seek();
        logic [7:0] v;
        int highs = 0, rises = 0, early = 0;
        logic prev = 1'b0;
        wr(8'hF0, 8'h02);
        wr(8'h90, 8'd3);
        wr(8'h70, 8'h81);
        for (int i = 0; i < 3 * P; i++) begin
            if (step_o) highs++;
            if (step_o && !prev) rises++;
            if (irq_o) early++;
            prev = step_o;
            @(negedge clk);
        end
        check("R7 step high clocks", highs, 3 * H);
        check("R7 step pulses", rises, 3);
        check("R7 no early done", early, 0);
        check("R7 seek done on time", irq_o, 1);
        check("R7 no step after done", step_o, 0);
        rd(8'h90, v);
        check("R7 count at zero", v, 0);
        rd(8'h80, v);
        check("R7 seek cause bit", v, 8'h02);
        wr(8'h60, 8'hFF);
    endtask

    task automatic test_halt();
        logic [7:0] v;
        int stray = 0;
        wr(8'h90, 8'd5);
        wr(8'h70, 8'h80);
        repeat (P + 4) @(negedge clk);
        wr(8'h60, 8'h80);
        for (int i = 0; i < 40; i++) begin
            if (step_o) stray++;
            @(negedge clk);
        end
        check("R8 no pulses after halt", stray, 0);
        rd(8'h90, v);
        check("R8 count held", v, 4);
        rd(8'h80, v);
        check("R8 no seek done", v, 0);
    endtask

    task automatic test_soft_reset();
        logic [7:0] v;
        wr(8'h70, 8'h5A);
        wr(8'h90, 8'd7);
        pulse(8'h01, 1, 0, 0);
        wr(8'h50, 8'h83);
        check("R11 control cleared", ctrl_o, 0);
        rd(8'h90, v);
        check("R11 count cleared", v, 0);
        rd(8'h20, v);
        check("R11 error cleared", v, 0);
        rd(8'h80, v);
        check("R11 intr cleared", v, 0);
        rd(8'h50, v);
        check("R11 setup bit7 not stored", v, 8'h03);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_plain();
        test_ctrl();
        test_status();
        test_errors();
        test_events();
        test_irq_mask();
        test_timer();
        test_seek();
        test_halt();
        test_soft_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule